// File: doc/BRIEF.md
# Vector Transpose Permute Unit

This unit takes a 32-bit vector transpose instruction word and two 128-bit source operands and returns the permuted result one clock later. The two operands come from a register file outside the unit. The unit passes the three register indices it decodes from the word back to that register file. A single datapath serves both variants. The even variant places the even-numbered elements of the two sources into the destination, interleaved. The odd variant does the same with the odd-numbered elements. Issuing both variants on the same pair of sources transposes every 2x2 block of elements.

The encoding selects the element width (8, 16, 32 or 64 bits) and the operating width (64 or 128 bits). A 64-bit element width with a 64-bit operating width is a reserved combination. Such a word raises the undefined flag and gives no result. A word that lacks the fixed opcode bits raises a separate not-recognised flag. The permutation depends only on the encoding fields, so the latency is the same for every operand value.

Top module: `vtrn_unit`

## Requirements
- R1: The cycle after `in_valid` is high, `out_rd`, `out_rn` and `out_rm` hold word bits [4:0], [9:5] and [20:16] of the sampled word. This holds whether or not the word decodes.
- R2: A word is recognised only if all of these hold: bit 31 is 0, bits [29:24] are 001110, bit 21 is 0, bit 15 is 0 and bits [13:10] are 1010. Any other word raises `out_unrec` one cycle later, with `out_valid` and `out_undef` low and `out_result` zero.
- R3: A recognised word with size (bits [23:22]) equal to 11 and Q (bit 30) equal to 0 raises `out_undef` one cycle later, with `out_valid` low and `out_result` zero.
- R4: With op (bit 14) equal to 0, result element 2p is element 2p of operand A, and result element 2p+1 is element 2p of operand B, for every pair p.
- R5: With op equal to 1, result element 2p is element 2p+1 of operand A, and result element 2p+1 is element 2p+1 of operand B.
- R6: The element width is 8 shifted left by size: 8, 16, 32 or 64 bits. All seven legal size/Q settings permute correctly.
- R7: With Q equal to 0, only the low 64 bits are permuted and `out_result[127:64]` is zero. With Q equal to 1, all 128 bits are permuted.
- R8: Outputs are registered with a latency of one cycle. A cycle with `in_valid` low gives all-zero outputs on the next cycle. The latency does not depend on operand values.
- R9: A synchronous active-high `rst` clears every output at the next clock edge, whatever the inputs are.
- R10: At most one of `out_valid`, `out_undef` and `out_unrec` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are present |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First source operand |
| in_opb | input | 128 | Second source operand |
| out_valid | output | 1 | Result is valid |
| out_undef | output | 1 | Reserved size/Q combination |
| out_unrec | output | 1 | Word is not a transpose instruction |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | First source register index |
| out_rm | output | 5 | Second source register index |
| out_result | output | 128 | Permuted result |

## Verification
The assertions assume that `in_insn` and `in_valid` are known values, not X, in every cycle after reset. They also compare each output with the inputs sampled one edge earlier. The bench therefore changes its inputs only on the falling edge and never leaves them undriven. Recognised words are built from the opcode fields, so every size/Q/op setting is reached. Random operands and one-bit corruptions of each fixed opcode bit are added on top. Idle cycles and a reset asserted during traffic are mixed in, so that the zero-output rules are exercised as well.

// File: rtl/vtrn_pkg.sv
package vtrn_pkg;
    localparam int VEC_W  = 128;
    localparam int INSN_W = 32;
    localparam int RIDX_W = 5;
    localparam int NSIZE  = 4;
    localparam int SIZE_W = $clog2(NSIZE);

    typedef struct packed {
        logic              match;
        logic              reserved;
        logic              op;
        logic              q;
        logic [SIZE_W-1:0] size;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rm;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic              unrec;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rm;
        logic [VEC_W-1:0]  result;
    } out_t;
endpackage

// File: rtl/vtrn_decode.sv
module vtrn_decode
    import vtrn_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    always_comb begin
        dec.match    = (insn[31] == 1'b0) && (insn[29:24] == 6'b001110) &&
                       (insn[21] == 1'b0) && (insn[15] == 1'b0) &&
                       (insn[13:10] == 4'b1010);
        dec.q        = insn[30];
        dec.size     = insn[23:22];
        dec.op       = insn[14];
        dec.reserved = (insn[23:22] == 2'b11) && !insn[30];
        dec.rd       = insn[4:0];
        dec.rn       = insn[9:5];
        dec.rm       = insn[20:16];
    end
endmodule

// File: rtl/vtrn_permute.sv
module vtrn_permute
    import vtrn_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              op,
    input  logic              q,
    input  logic [SIZE_W-1:0] size,
    output logic [W-1:0]      result
);
    localparam int HALF = W / 2;

    logic [W-1:0] cand [NSIZE];

    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        localparam int ES = 8 << s;
        localparam int NP = W / ES / 2;
        for (genvar p = 0; p < NP; p++) begin : g_pair
            assign cand[s][(2*p)*ES +: ES]   = op ? opa[(2*p+1)*ES +: ES] : opa[(2*p)*ES +: ES];
            assign cand[s][(2*p+1)*ES +: ES] = op ? opb[(2*p+1)*ES +: ES] : opb[(2*p)*ES +: ES];
        end
    end

    logic [W-1:0] sel;
    always_comb begin
        sel    = cand[size];
        result = q ? sel : {{HALF{1'b0}}, sel[HALF-1:0]};
    end
endmodule

// File: rtl/vtrn_unit.sv
module vtrn_unit
    import vtrn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [VEC_W-1:0]  in_opa,
    input  logic [VEC_W-1:0]  in_opb,
    output logic              out_valid,
    output logic              out_undef,
    output logic              out_unrec,
    output logic [RIDX_W-1:0] out_rd,
    output logic [RIDX_W-1:0] out_rn,
    output logic [RIDX_W-1:0] out_rm,
    output logic [VEC_W-1:0]  out_result
);
    dec_t             dec;
    logic [VEC_W-1:0] perm;
    out_t             out_d, out_q;

    vtrn_decode u_dec (.insn(in_insn), .dec(dec));

    vtrn_permute #(.W(VEC_W)) u_perm (
        .opa(in_opa), .opb(in_opb), .op(dec.op), .q(dec.q),
        .size(dec.size), .result(perm)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.rd = dec.rd;
            out_d.rn = dec.rn;
            out_d.rm = dec.rm;
            if (!dec.match) begin
                out_d.unrec = 1'b1;
            end else if (dec.reserved) begin
                out_d.undef = 1'b1;
            end else begin
                out_d.valid  = 1'b1;
                out_d.result = perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid  = out_q.valid;
    assign out_undef  = out_q.undef;
    assign out_unrec  = out_q.unrec;
    assign out_rd     = out_q.rd;
    assign out_rn     = out_q.rn;
    assign out_rm     = out_q.rm;
    assign out_result = out_q.result;
endmodule

// File: rtl/vtrn_unit_chk.sv
module vtrn_unit_chk
    import vtrn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [INSN_W-1:0] in_insn,
    input logic              out_valid,
    input logic              out_undef,
    input logic              out_unrec,
    input logic [RIDX_W-1:0] out_rd,
    input logic [VEC_W-1:0]  out_result
);
    logic fixed_ok;
    assign fixed_ok = !in_insn[31] && in_insn[29:24] == 6'b001110 && !in_insn[21] &&
                      !in_insn[15] && in_insn[13:10] == 4'b1010;

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_undef, out_unrec}));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_undef && !out_unrec && out_result == '0);

    assert_unrec_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && !fixed_ok |=> out_unrec && !out_valid);

    assert_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && fixed_ok && in_insn[23:22] == 2'b11 && !in_insn[30]
        |=> out_undef && !out_valid && out_result == '0);

    assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_insn[30] |=> out_result[VEC_W-1:VEC_W/2] == '0);

    assert_rd_index_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_rd == $past(in_insn[4:0]));
endmodule

bind vtrn_unit vtrn_unit_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .out_undef(out_undef), .out_unrec(out_unrec),
    .out_rd(out_rd), .out_result(out_result)
);

// File: tb/vtrn_unit_test.sv
module vtrn_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  in_insn;
    logic [127:0] in_opa, in_opb;
    logic         out_valid, out_undef, out_unrec;
    logic [4:0]   out_rd, out_rn, out_rm;
    logic [127:0] out_result;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 0;

    logic         e_valid, e_undef, e_unrec;
    logic [4:0]   e_rd, e_rn, e_rm;
    logic [127:0] e_res;

    always #2 clk = ~clk;

    vtrn_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid),
        .out_undef(out_undef), .out_unrec(out_unrec), .out_rd(out_rd),
        .out_rn(out_rn), .out_rm(out_rm), .out_result(out_result)
    );

    function automatic logic [31:0] mk(bit op, bit [1:0] sz, bit q, bit [4:0] rd, bit [4:0] rn, bit [4:0] rm);
        return {1'b0, q, 6'b001110, sz, 1'b0, rm, 1'b0, op, 4'b1010, rn, rd};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Behavioural loop model of the permutation (R4..R7)
    function automatic logic [127:0] model(logic [31:0] w, logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int es   = 8 << w[23:22];
        int dw   = w[30] ? 128 : 64;
        int part = w[14];
        for (int p = 0; p < dw / es / 2; p++)
            for (int k = 0; k < es; k++) begin
                r[(2*p)*es + k]   = a[(2*p+part)*es + k];
                r[(2*p+1)*es + k] = b[(2*p+part)*es + k];
            end
        return r;
    endfunction

    task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, compare one full cycle later (one register stage)
    task automatic step(bit r, bit v, logic [31:0] w, logic [127:0] a, logic [127:0] b, string tag);
        bit fx;
        rst = r; in_valid = v; in_insn = w; in_opa = a; in_opb = b;
        fx = !w[31] && w[29:24] == 6'b001110 && !w[21] && !w[15] && w[13:10] == 4'b1010;
        {e_valid, e_undef, e_unrec, e_rd, e_rn, e_rm, e_res} = '0;
        if (!r && v) begin
            e_rd = w[4:0]; e_rn = w[9:5]; e_rm = w[20:16];
            if (!fx) e_unrec = 1;
            else if (w[23:22] == 2'b11 && !w[30]) e_undef = 1;
            else begin e_valid = 1; e_res = model(w, a, b); end
        end
        @(negedge clk);
        cmp({tag, " R1 indices"}, {113'b0, out_rd, out_rn, out_rm}, {113'b0, e_rd, e_rn, e_rm});
        cmp({tag, " R10 flags"}, {125'b0, out_valid, out_undef, out_unrec}, {125'b0, e_valid, e_undef, e_unrec});
        cmp({tag, " result"}, out_result, e_res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_insn = '0; in_opa = '0; in_opb = '0;
        @(negedge clk);
        // R9: reset clears even with a valid word present
        step(1, 1, mk(0, 0, 1, 1, 2, 3), rnd128(), rnd128(), "R9 reset");
        step(1, 1, mk(1, 2, 1, 4, 5, 6), rnd128(), rnd128(), "R9 reset");
        // R8: idle cycle gives zeros
        step(0, 0, mk(0, 1, 1, 7, 8, 9), rnd128(), rnd128(), "R8 idle");
        // R4 R5 R6 R7 R3: sweep op, size, Q with random operands
        for (int op = 0; op < 2; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int q = 0; q < 2; q++)
                    for (int k = 0; k < 6; k++)
                        step(0, 1, mk(op[0], sz[1:0], q[0], 5'($urandom), 5'($urandom), 5'($urandom)),
                             rnd128(), rnd128(), op ? "R5 odd R6 R7" : "R4 even R6 R7 R3");
        // Structured operands: element index patterns (R4 R5)
        for (int sz = 0; sz < 4; sz++) begin
            logic [127:0] a = '0, b = '0;
            for (int i = 0; i < 16; i++) begin a[i*8 +: 8] = 8'(i); b[i*8 +: 8] = 8'(8'h80 | i); end
            step(0, 1, mk(0, sz[1:0], 1, 1, 2, 3), a, b, "R4 pattern");
            step(0, 1, mk(1, sz[1:0], 1, 1, 2, 3), a, b, "R5 pattern");
        end
        // R2: flip each fixed bit in turn
        foreach (in_insn[i]) begin end
        for (int bit_i = 0; bit_i < 32; bit_i++) begin
            if (bit_i == 31 || (bit_i >= 24 && bit_i <= 29) || bit_i == 21 || bit_i == 15 ||
                (bit_i >= 10 && bit_i <= 13))
                step(0, 1, mk(1, 1, 1, 10, 11, 12) ^ (32'd1 << bit_i), rnd128(), rnd128(), "R2 fixed-bit");
        end
        // Mixed random traffic with idles and mid-run reset (R8 R9 R2)
        for (int k = 0; k < 400; k++) begin
            int sel = $urandom_range(0, 9);
            logic [31:0] w = (sel < 2) ? $urandom
                           : mk(1'($urandom), 2'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
            step(sel == 9, sel != 8, w, rnd128(), rnd128(), "R8 R9 mixed");
        end
        step(0, 0, '0, '0, '0, "R8 final idle");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule